// File: doc/BRIEF.md
# I2C Address Recognizer and Role Tracker

This block follows a byte-level view of an I2C bus and decides two things: whether the device is the target of the current transfer, and which of four roles it holds. The four roles are slave receiver, slave transmitter, master transmitter and master receiver. Its inputs are one-cycle strobes for bus START, bus STOP, lost arbitration and a START that this device generated itself, plus each received byte with a valid strobe. Configuration sets an own address of 7 or 10 bits and enables or disables the General Call address.

The device starts out as a slave. It becomes a master when it issues its own START. It goes back to slave when a STOP is seen or when it loses arbitration. As a slave, it compares the first byte after each START, or the first two bytes in 10-bit mode, with its own address. The direction bit that comes with a matching address selects the slave role. As a master, the direction bit of the byte it sends selects between the transmitter and receiver roles. Bit sampling and clock generation are handled by other logic.

Top module: `i2c_addr_role_tracker`

## Requirements
- R1: After reset, role is 2'b00 (slave receiver), and addr_match, gc_hit and dir_tx are 0.
- R2: own_start_i moves role to 2'b10 (master transmitter) on the next cycle. While the device is master, the first byte after START sets role to 2'b10 if its bit 0 is 0 and to 2'b11 (master receiver) if its bit 0 is 1. addr_match stays 0 while the device is master.
- R3: stop_i or arb_lost_i returns role to 2'b00 on the next cycle. These two inputs take priority over a START or a byte in the same cycle.
- R4: With cfg_ten_bit=0, a first byte after START whose bits 7:1 equal cfg_own_addr[6:0] sets addr_match. Role becomes 2'b01 (slave transmitter) if bit 0 of that byte is 1, and 2'b00 if it is 0.
- R5: With cfg_ten_bit=1, a first byte 11110 a9 a8 0 followed by a second byte a7..a0 sets addr_match with role 2'b00. A 7-bit style byte gives no match in this mode.
- R6: With cfg_ten_bit=1, after a 10-bit write match, a repeated START followed by the header 11110 a9 a8 1 sets addr_match with role 2'b01. The same header with no 10-bit write match since the last STOP or arbitration loss gives no match.
- R7: With cfg_gc_en=1, a first byte of 0x00 sets both addr_match and gc_hit with role 2'b00. With cfg_gc_en=0, byte 0x00 gives no match. Byte 0x01 never counts as General Call.
- R8: STOP clears addr_match and gc_hit on the next cycle. A START also clears them until the new address is evaluated.
- R9: Data bytes after the address phase leave addr_match, gc_hit and role unchanged.
- R10: dir_tx is 1 exactly when role is 2'b01 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Bus START or repeated START seen |
| stop_i | input | 1 | Bus STOP seen |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| own_start_i | input | 1 | START issued by this device |
| rx_byte_i | input | 8 | Byte received from the bus, MSB first on the wire |
| rx_valid_i | input | 1 | rx_byte_i is valid this cycle |
| cfg_own_addr_i | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| cfg_ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en_i | input | 1 | 1 enables General Call recognition |
| addr_match_o | output | 1 | Device is the addressed target |
| gc_hit_o | output | 1 | Match came from the General Call address |
| role_o | output | 2 | 00 slave rx, 01 slave tx, 10 master tx, 11 master rx |
| dir_tx_o | output | 1 | Device drives data bytes |

## Verification
A table of address transfers runs the matcher on several cases. These include 7-bit hits with both direction bits and a 7-bit miss by one bit. They also include General Call with the enable on and off, and General Call with the read bit set. For 10-bit mode, the table covers a full header-plus-low-byte hit and near misses in the upper bits and in the low byte. One case sends a 7-bit form byte while 10-bit mode is selected, which shows whether the two modes are kept separate. Directed sequences then check the role changes: master on own START, the transmit or receive choice from the sent direction bit, and the return to slave on STOP or lost arbitration. They also check the 10-bit read with and without a prior write match, and that data bytes cannot overwrite the address result.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;

    typedef enum logic [1:0] {
        ROLE_SLV_RX = 2'b00,
        ROLE_SLV_TX = 2'b01,
        ROLE_MST_TX = 2'b10,
        ROLE_MST_RX = 2'b11
    } role_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_FIRST  = 2'b01,
        PH_SECOND = 2'b10,
        PH_DATA   = 2'b11
    } phase_t;

    typedef struct packed {
        phase_t phase;
        role_t  role;
        logic   match;
        logic   gc;
        logic   ten_ok;
    } trk_t;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              gc_en,
    output logic              hit7,
    output logic              hdr10,
    output logic              lo10,
    output logic              gc_code
);
    localparam int          HI_W    = ADDR_W - BYTE_W;
    localparam int          TAG_W   = BYTE_W - 1 - HI_W;
    localparam logic [TAG_W-1:0] HDR_TAG = '1 << 1;

    always_comb begin
        hit7    = !ten_bit && (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
        hdr10   = ten_bit
                  && (rx_byte[BYTE_W-1 -: TAG_W] == HDR_TAG)
                  && (rx_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
        lo10    = (rx_byte == own_addr[BYTE_W-1:0]);
        gc_code = gc_en && (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl
    import i2c_role_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  arb_lost_i,
    input  logic  own_start_i,
    input  logic  rx_valid_i,
    input  logic  rx_lsb_i,
    input  logic  hit7_i,
    input  logic  hdr10_i,
    input  logic  lo10_i,
    input  logic  gc_code_i,
    output role_t role_o,
    output logic  match_o,
    output logic  gc_o
);
    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i || arb_lost_i) begin
            st_d.phase  = PH_IDLE;
            st_d.role   = ROLE_SLV_RX;
            st_d.match  = 1'b0;
            st_d.gc     = 1'b0;
            st_d.ten_ok = 1'b0;
        end else if (start_i || own_start_i) begin
            st_d.phase = PH_FIRST;
            st_d.match = 1'b0;
            st_d.gc    = 1'b0;
            if (own_start_i)
                st_d.role = ROLE_MST_TX;
            else if (!st_q.role[1])
                st_d.role = ROLE_SLV_RX;
        end else if (rx_valid_i) begin
            case (st_q.phase)
                PH_FIRST: begin
                    st_d.phase = PH_DATA;
                    if (st_q.role[1]) begin
                        st_d.role = rx_lsb_i ? ROLE_MST_RX : ROLE_MST_TX;
                    end else if (gc_code_i) begin
                        st_d.match = 1'b1;
                        st_d.gc    = 1'b1;
                        st_d.role  = ROLE_SLV_RX;
                    end else if (hit7_i) begin
                        st_d.match = 1'b1;
                        st_d.role  = rx_lsb_i ? ROLE_SLV_TX : ROLE_SLV_RX;
                    end else if (hdr10_i) begin
                        if (!rx_lsb_i) begin
                            st_d.phase = PH_SECOND;
                        end else if (st_q.ten_ok) begin
                            st_d.match = 1'b1;
                            st_d.role  = ROLE_SLV_TX;
                        end
                    end
                end
                PH_SECOND: begin
                    st_d.phase = PH_DATA;
                    if (lo10_i) begin
                        st_d.match  = 1'b1;
                        st_d.ten_ok = 1'b1;
                        st_d.role   = ROLE_SLV_RX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, role: ROLE_SLV_RX, match: 1'b0, gc: 1'b0, ten_ok: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign role_o  = st_q.role;
    assign match_o = st_q.match;
    assign gc_o    = st_q.gc;

    p_stop_to_slave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i || arb_lost_i) |=> (role_o == ROLE_SLV_RX));
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!match_o && !gc_o));
    p_own_start_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_start_i && !stop_i && !arb_lost_i) |=> (role_o == ROLE_MST_TX));
    p_master_no_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        role_o[1] |-> !match_o);
    p_gc_implies_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_o |-> match_o);
    p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && st_q.phase == PH_DATA && !start_i && !stop_i && !arb_lost_i && !own_start_i)
        |=> ($stable(match_o) && $stable(role_o) && $stable(gc_o)));
endmodule

// File: rtl/i2c_addr_role_tracker.sv
module i2c_addr_role_tracker
    import i2c_role_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              arb_lost_i,
    input  logic              own_start_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              rx_valid_i,
    input  logic [ADDR_W-1:0] cfg_own_addr_i,
    input  logic              cfg_ten_bit_i,
    input  logic              cfg_gc_en_i,
    output logic              addr_match_o,
    output logic              gc_hit_o,
    output logic [1:0]        role_o,
    output logic              dir_tx_o
);
    logic  hit7, hdr10, lo10, gc_code;
    role_t role;

    i2c_addr_cmp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cmp (
        .rx_byte  (rx_byte_i),
        .own_addr (cfg_own_addr_i),
        .ten_bit  (cfg_ten_bit_i),
        .gc_en    (cfg_gc_en_i),
        .hit7     (hit7),
        .hdr10    (hdr10),
        .lo10     (lo10),
        .gc_code  (gc_code)
    );

    i2c_role_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .arb_lost_i  (arb_lost_i),
        .own_start_i (own_start_i),
        .rx_valid_i  (rx_valid_i),
        .rx_lsb_i    (rx_byte_i[0]),
        .hit7_i      (hit7),
        .hdr10_i     (hdr10),
        .lo10_i      (lo10),
        .gc_code_i   (gc_code),
        .role_o      (role),
        .match_o     (addr_match_o),
        .gc_o        (gc_hit_o)
    );

    assign role_o   = role;
    assign dir_tx_o = (role == ROLE_SLV_TX) || (role == ROLE_MST_TX);

    p_gc_needs_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit_o |-> (role_o == 2'b00));
endmodule

// File: tb/sim_i2c_addr_role_tracker.sv
module sim_i2c_addr_role_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, arb_lost_i = 1'b0, own_start_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic       rx_valid_i = 1'b0;
    logic [9:0] cfg_own_addr_i = 10'h000;
    logic       cfg_ten_bit_i = 1'b0, cfg_gc_en_i = 1'b0;
    logic       addr_match_o, gc_hit_o, dir_tx_o;
    logic [1:0] role_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_role_tracker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .arb_lost_i(arb_lost_i), .own_start_i(own_start_i),
        .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i),
        .cfg_own_addr_i(cfg_own_addr_i), .cfg_ten_bit_i(cfg_ten_bit_i),
        .cfg_gc_en_i(cfg_gc_en_i), .addr_match_o(addr_match_o),
        .gc_hit_o(gc_hit_o), .role_o(role_o), .dir_tx_o(dir_tx_o)
    );

    typedef struct packed {
        logic       ten;
        logic       gc_en;
        logic [9:0] own;
        logic [7:0] b0;
        logic [7:0] b1;
        logic       two;
        logic       m;
        logic       g;
        logic [1:0] r;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 10'h02A, 8'h54, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00},
        '{1'b0, 1'b0, 10'h02A, 8'h55, 8'h00, 1'b0, 1'b1, 1'b0, 2'b01},
        '{1'b0, 1'b0, 10'h02A, 8'h56, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b0, 1'b1, 10'h02A, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 2'b00},
        '{1'b0, 1'b0, 10'h02A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b0, 1'b1, 10'h02A, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b1, 1'b0, 10'h2A5, 8'hF4, 8'hA5, 1'b1, 1'b1, 1'b0, 2'b00},
        '{1'b1, 1'b0, 10'h2A5, 8'hF4, 8'hA4, 1'b1, 1'b0, 1'b0, 2'b00},
        '{1'b1, 1'b0, 10'h2A5, 8'hF2, 8'hA5, 1'b1, 1'b0, 1'b0, 2'b00},
        '{1'b1, 1'b0, 10'h2A5, 8'h4A, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b0, 1'b0, 10'h2A5, 8'h4B, 8'h00, 1'b0, 1'b1, 1'b0, 2'b01},
        '{1'b1, 1'b1, 10'h2A5, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 2'b00}
    };

    task automatic chk(input string req, input logic m, input logic g, input logic [1:0] r);
        logic d;
        d = (r == 2'b01) || (r == 2'b10);
        checks++;
        if (addr_match_o !== m || gc_hit_o !== g || role_o !== r || dir_tx_o !== d) begin
            failures++;
            $display("FAIL %s: match/gc/role/dir got %b/%b/%b/%b expected %b/%b/%b/%b",
                     req, addr_match_o, gc_hit_o, role_o, dir_tx_o, m, g, r, d);
        end
    endtask

    task automatic ev(input logic s, input logic p, input logic a, input logic o);
        start_i = s; stop_i = p; arb_lost_i = a; own_start_i = o;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0; arb_lost_i = 1'b0; own_start_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte_i = b; rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0, 2'b00);

        // R4 R5 R7 R10: address table
        for (int i = 0; i < NVEC; i++) begin
            cfg_ten_bit_i  = VECS[i].ten;
            cfg_gc_en_i    = VECS[i].gc_en;
            cfg_own_addr_i = VECS[i].own;
            ev(1'b0, 1'b1, 1'b0, 1'b0);
            ev(1'b1, 1'b0, 1'b0, 1'b0);
            send(VECS[i].b0);
            if (VECS[i].two) send(VECS[i].b1);
            chk($sformatf("R4/R5/R7 vector %0d", i), VECS[i].m, VECS[i].g, VECS[i].r);
        end

        // R9: data bytes after a match change nothing
        cfg_ten_bit_i = 1'b0; cfg_gc_en_i = 1'b1; cfg_own_addr_i = 10'h02A;
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h55);
        send(8'h00);
        send(8'h54);
        chk("R9 data ignored", 1'b1, 1'b0, 2'b01);

        // R8: STOP clears match
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 stop clears", 1'b0, 1'b0, 2'b00);

        // R8: repeated START clears until re-evaluated
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h54);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 restart clears", 1'b0, 1'b0, 2'b00);

        // R2: own START, master roles from sent direction bit
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        ev(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R2 own start master tx", 1'b0, 1'b0, 2'b10);
        send(8'h55);
        chk("R2 master rx, no slave match", 1'b0, 1'b0, 2'b11);
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 stop returns to slave", 1'b0, 1'b0, 2'b00);
        ev(1'b1, 1'b0, 1'b0, 1'b1);
        send(8'h54);
        chk("R2 master tx own-address byte", 1'b0, 1'b0, 2'b10);
        ev(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 arb lost returns to slave", 1'b0, 1'b0, 2'b00);

        // R3: stop wins over own start in same cycle
        ev(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R3 stop priority", 1'b0, 1'b0, 2'b00);

        // R6: 10-bit read after write match
        cfg_ten_bit_i = 1'b1; cfg_gc_en_i = 1'b0; cfg_own_addr_i = 10'h2A5;
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'hF4);
        send(8'hA5);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'hF5);
        chk("R6 10-bit read after write", 1'b1, 1'b0, 2'b01);

        // R6: read header alone after STOP
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'hF5);
        chk("R6 10-bit read without write", 1'b0, 1'b0, 2'b00);

        // R1: reset in mid-transfer
        ev(1'b1, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset from master", 1'b0, 1'b0, 2'b00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule